// File: doc/BRIEF.md
# Dual-level masked interrupt controller

This block gathers up to 31 level-sensitive peripheral request lines and steers each of them to one of two active-high outputs for the processor core. One output is the normal interrupt, and the other is the fast, high-priority interrupt. Each output level keeps its own enable mask. A request that is enabled at a level shows up in that level's status vector. The status bits of a level are ORed together, registered, and driven to the core.

Software changes a mask through two write-only registers. One sets mask bits and the other clears them, so no read-modify-write is ever needed. The hardware keeps a source from being enabled at both levels: setting a bit at one level clears the same bit at the other level in the same clock edge.

Bit 0 of each level's source vector is not a peripheral line. It carries the OR of the fast-level status bits 31 down to 1, so the normal level can also report that a fast interrupt is pending.

The register port is a plain single-cycle port. It takes an address, a write strobe and write data, and returns read data combinationally for the current address. Reads have no side effects. This is a control port, so it has no handshake and never stalls.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: After reset both enable masks are 0x00000000, and `irq_o` and `fiq_o` are low.
- R2: A write to an enable register (normal level at 0x008, fast level at 0x108) sets every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value. A read of the same address returns the mask.
- R3: A write to a clear register (normal level at 0x00C, fast level at 0x10C) clears every mask bit whose data bit is 1 and leaves the others alone. Reads of a clear register return zero.
- R4: Setting a bit through one level's enable register clears the same bit in the other level's mask at the same clock edge. No bit is ever 1 in both masks. A bit may be 0 in both masks.
- R5: Each level's status vector equals its source vector ANDed with its mask. The normal-level status reads at 0x000 and the fast-level status reads at 0x100.
- R6: The source vector reads at 0x004 (normal level) and at 0x104 (fast level). Bits 31 to 1 follow the request lines `req_i[31:1]`. Bit 0 is the OR of the fast-level status bits 31 to 1.
- R7: `fiq_o` is, one clock later, the OR of the fast-level status bits 31 to 1.
- R8: `irq_o` is, one clock later, the OR of all 32 normal-level status bits. This includes bit 0, the fast-pending feedback.
- R9: Writes to status, source or unmapped addresses change no mask bit. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 31 | Peripheral request levels, bits 31 to 1 |
| reg_addr_i | input | 12 | Register byte address |
| reg_we_i | input | 1 | Write strobe for the current address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the current address, combinational |
| irq_o | output | 1 | Registered normal-level interrupt to the core |
| fiq_o | output | 1 | Registered fast-level interrupt to the core |

## Verification
The hardest case to reach from the ports is the feedback route. Here a request that is enabled only at the fast level must raise `irq_o` through bit 0. That needs the normal mask bit 0 set while the same source is masked at the normal level and unmasked at the fast level. It is also hard to show that the cross-level clear works while the other mask bits stay untouched. Directed sequences build both situations step by step. Random stimulus then mixes set, clear and stray writes with sparse request patterns, so that single pending sources, and changes of mask ownership while a request is active, come up often.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Register byte offsets
  localparam int unsigned OFS_N_STAT = 'h000;
  localparam int unsigned OFS_N_SRC  = 'h004;
  localparam int unsigned OFS_N_SET  = 'h008;
  localparam int unsigned OFS_N_CLR  = 'h00C;
  localparam int unsigned OFS_F_STAT = 'h100;
  localparam int unsigned OFS_F_SRC  = 'h104;
  localparam int unsigned OFS_F_SET  = 'h108;
  localparam int unsigned OFS_F_CLR  = 'h10C;

  localparam int unsigned NUM_LVL = 2;

  typedef enum logic [0:0] {
    LVL_NORM = 1'b0,
    LVL_FAST = 1'b1
  } level_e;

  typedef struct packed {
    logic set;
    logic clr;
  } mask_cmd_t;

endpackage

// File: rtl/irqc_mask.sv
module irqc_mask #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic         xclr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o
);

  logic [W-1:0] en_q;
  logic [W-1:0] en_nxt;

  // The clear is applied last, so it wins over a set of the same bit.
  always_comb begin
    en_nxt = en_q;
    if (set_i)  en_nxt = en_nxt | wdata_i;
    if (xclr_i) en_nxt = en_nxt & ~wdata_i;
    if (clr_i)  en_nxt = en_nxt & ~wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_nxt;
  end

  assign en_o = en_q;

  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i && !xclr_i) |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));

  assert_set_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i && !xclr_i) |=> ((en_q & ~$past(wdata_i)) == ($past(en_q) & ~$past(wdata_i))));

  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i || xclr_i) |=> ((en_q & $past(wdata_i)) == '0));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i && !xclr_i) |=> $stable(en_q));

endmodule

// File: rtl/irqc_status.sv
module irqc_status #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:1] req_i,
  input  logic [W-1:0] n_en_i,
  input  logic [W-1:0] f_en_i,
  output logic [W-1:0] src_o,
  output logic [W-1:0] n_stat_o,
  output logic [W-1:0] f_stat_o,
  output logic         fast_any_o,
  output logic         norm_any_o
);

  logic [W-1:1] f_upper;

  // Bits 31..1 of the fast status feed back into bit 0; bit 0 itself is
  // left out of the OR, so there is no loop.
  assign f_upper    = req_i & f_en_i[W-1:1];
  assign fast_any_o = |f_upper;
  assign src_o      = {req_i, fast_any_o};
  assign n_stat_o   = src_o & n_en_i;
  assign f_stat_o   = src_o & f_en_i;
  assign norm_any_o = |n_stat_o;

endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
  import irqc_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned W  = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [W-1:0]  src_i,
  input  logic [W-1:0]  n_stat_i,
  input  logic [W-1:0]  f_stat_i,
  input  logic [W-1:0]  n_en_i,
  input  logic [W-1:0]  f_en_i,
  output mask_cmd_t     cmd_o [NUM_LVL],
  output logic [W-1:0]  rdata_o
);

  always_comb begin
    for (int l = 0; l < NUM_LVL; l++) cmd_o[l] = '0;
    rdata_o = '0;
    case (addr_i)
      AW'(OFS_N_STAT): rdata_o = n_stat_i;
      AW'(OFS_N_SRC):  rdata_o = src_i;
      AW'(OFS_N_SET): begin
        rdata_o            = n_en_i;
        cmd_o[LVL_NORM].set = we_i;
      end
      AW'(OFS_N_CLR):  cmd_o[LVL_NORM].clr = we_i;
      AW'(OFS_F_STAT): rdata_o = f_stat_i;
      AW'(OFS_F_SRC):  rdata_o = src_i;
      AW'(OFS_F_SET): begin
        rdata_o            = f_en_i;
        cmd_o[LVL_FAST].set = we_i;
      end
      AW'(OFS_F_CLR):  cmd_o[LVL_FAST].clr = we_i;
      default:         rdata_o = '0;
    endcase
  end

  // Only one mask command can come from one write.
  always_comb begin
    assert_one_cmd_R9: assert ($countones({cmd_o[0].set, cmd_o[0].clr,
                                           cmd_o[1].set, cmd_o[1].clr}) <= 1);
  end

endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:1]   req_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [NSRC-1:0]   reg_wdata_i,
  output logic [NSRC-1:0]   reg_rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);

  mask_cmd_t         cmd [NUM_LVL];
  logic [NSRC-1:0]   en  [NUM_LVL];
  logic [NSRC-1:0]   src;
  logic [NSRC-1:0]   n_stat;
  logic [NSRC-1:0]   f_stat;
  logic              fast_any;
  logic              norm_any;

  irqc_regif #(.AW(ADDR_W), .W(NSRC)) u_regif (
    .addr_i   (reg_addr_i),
    .we_i     (reg_we_i),
    .src_i    (src),
    .n_stat_i (n_stat),
    .f_stat_i (f_stat),
    .n_en_i   (en[LVL_NORM]),
    .f_en_i   (en[LVL_FAST]),
    .cmd_o    (cmd),
    .rdata_o  (reg_rdata_o)
  );

  // One mask per level; a set at one level is the cross-clear of the other.
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    irqc_mask #(.W(NSRC)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (cmd[l].set),
      .clr_i   (cmd[l].clr),
      .xclr_i  (cmd[NUM_LVL-1-l].set),
      .wdata_i (reg_wdata_i),
      .en_o    (en[l])
    );
  end

  irqc_status #(.W(NSRC)) u_status (
    .req_i      (req_i),
    .n_en_i     (en[LVL_NORM]),
    .f_en_i     (en[LVL_FAST]),
    .src_o      (src),
    .n_stat_o   (n_stat),
    .f_stat_o   (f_stat),
    .fast_any_o (fast_any),
    .norm_any_o (norm_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= norm_any;
      fiq_o <= fast_any;
    end
  end

  assert_masks_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en[LVL_NORM] & en[LVL_FAST]) == '0);

  assert_fiq_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fiq_o == $past(|(f_stat[NSRC-1:1]))));

  assert_irq_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|n_stat)));

  assert_feedback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    src[0] == (|(f_stat[NSRC-1:1])));

endmodule

// File: tb/irq_fiq_ctrl_tb.sv
`timescale 1ns/1ps
module irq_fiq_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:1] req;
  logic [11:0] addr;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq_o, fiq_o;

  always #2 clk = ~clk;

  irq_fiq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .reg_addr_i(addr),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;
  logic [31:0] m_ne, m_fe;

  function automatic logic m_fany();
    return |(req & m_fe[31:1]);
  endfunction

  function automatic logic [31:0] m_src();
    return {req, m_fany()};
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      12'h000: return m_src() & m_ne;
      12'h004: return m_src();
      12'h008: return m_ne;
      12'h100: return m_src() & m_fe;
      12'h104: return m_src();
      12'h108: return m_fe;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(posedge clk);
    case (a)
      12'h008: begin m_ne = m_ne | d; m_fe = m_fe & ~d; end
      12'h00C: m_ne = m_ne & ~d;
      12'h108: begin m_fe = m_fe | d; m_ne = m_ne & ~d; end
      12'h10C: m_fe = m_fe & ~d;
      default: ;
    endcase
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [11:0] a);
    addr = a;
    #0.5;
    chk(tag, rdata, m_read(a));
  endtask

  // One edge so the registered outputs pick up the current state.
  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_outs(input string tag);
    chk({tag, " R8 irq_o"}, {31'h0, irq_o}, {31'h0, |(m_src() & m_ne)});
    chk({tag, " R7 fiq_o"}, {31'h0, fiq_o}, {31'h0, m_fany()});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  localparam logic [11:0] ADDRS [10] = '{12'h000, 12'h004, 12'h008, 12'h00C,
    12'h100, 12'h104, 12'h108, 12'h10C, 12'h200, 12'h0F0};

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req = '0; addr = '0; we = 1'b0; wdata = '0;
    m_ne = '0; m_fe = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 irq_o at reset", {31'h0, irq_o}, 32'h0);
    chk("R1 fiq_o at reset", {31'h0, fiq_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd("R1 normal mask after reset", 12'h008);
    rd("R1 fast mask after reset", 12'h108);

    // R2: set bits, then write zeros which must not disable anything
    wr(12'h008, 32'h0000_00F0);
    rd("R2 normal mask set", 12'h008);
    wr(12'h008, 32'h0);
    chk("R2 zero write keeps mask", rdata, 32'h0000_00F0);
    rd("R2 zero write keeps mask", 12'h008);

    // R4: taking bit 5 into the fast level clears it from the normal level
    wr(12'h108, 32'h0000_0020);
    rd("R4 normal lost bit 5", 12'h008);
    rd("R4 fast gained bit 5", 12'h108);

    // R3: clear one bit, others stay; clear register reads zero
    wr(12'h00C, 32'h0000_0040);
    rd("R3 normal clear bit 6", 12'h008);
    rd("R3 clear register reads zero", 12'h00C);
    rd("R3 fast clear register reads zero", 12'h10C);

    // R6/R7/R8: fast-only source raises both outputs via bit 0 feedback
    wr(12'h008, 32'h0000_0001);
    @(negedge clk); req = 31'h0; req[5] = 1'b1;
    settle();
    rd("R6 source bit 0 feedback", 12'h004);
    rd("R6 fast source view", 12'h104);
    rd("R5 normal status", 12'h000);
    rd("R5 fast status", 12'h100);
    chk("R8 irq_o through feedback", {31'h0, irq_o}, 32'h1);
    chk("R7 fiq_o fast source", {31'h0, fiq_o}, 32'h1);

    // R9: stray writes leave masks untouched, unmapped reads zero
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h104, 32'hFFFF_FFFF);
    wr(12'h200, 32'hFFFF_FFFF);
    rd("R9 normal mask after stray writes", 12'h008);
    rd("R9 fast mask after stray writes", 12'h108);
    addr = 12'h200; #0.5;
    chk("R9 unmapped read", rdata, 32'h0);
    settle();
    chk_outs("R9 outputs after stray writes");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      a = ADDRS[$urandom_range(9, 0)];
      if ($urandom_range(2, 0) == 0) begin
        @(negedge clk);
        req = 31'($urandom & $urandom & $urandom);
      end
      wr(a, $urandom & $urandom);
      settle();
      chk_outs("R7 R8 random");
      rd("R5 R6 R2 R3 R4 random read", ADDRS[$urandom_range(9, 0)]);
      chk("R4 masks exclusive", m_ne & m_fe, 32'h0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule